// File: doc/BRIEF.md
# Nonvolatile Wiper Register Controller

This block holds the volatile wiper registers of a dual-channel digital potentiometer and a register model of its nonvolatile array. Each wiper has its own nonvolatile slot. The array also holds twelve general-purpose user bytes. A serial front end decodes bus traffic into single-cycle requests of three kinds: register write, register read and quick command. The controller carries them out: direct wiper writes, nonvolatile writes, store (wiper to slot), restore (slot to wiper), linear steps and doubling/halving steps.

A nonvolatile write, a store or a restore opens a busy window of a parameterised number of clock cycles. While `busy` is high, the front end NACKs its address, and the block drops every request it is given. At power-up every wiper sits at midscale, and the block is busy for the restore interval. At the end of that interval each wiper takes the value in its slot. When the write-protect input is low, the block refuses every change to either register type and every quick command, but reads still work.

Top module: `nvw_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and every wiper equals midscale (bit W-1 set, all other bits 0). After release, `busy` stays high for RESTORE_CYCLES cycles and the wipers stay at midscale. On the edge that ends the window, each wiper loads the low W bits of its slot; after reset every slot holds SLOT_INIT.
- R2: Wiper channel k lives at address 2k+1 (addresses 1 and 3). A write request (`req_op`=0, `req_nv`=0) to one of these addresses sets that wiper to `req_data` on the next clock edge and does not raise `busy`.
- R3: A write request with `req_nv`=1 to a slot address (1, 3) or to a user byte (4 to 15) stores `req_data` there. `busy` is then high for exactly BUSY_CYCLES cycles, starting in the cycle after the request.
- R4: Any request presented while `busy` is high has no effect: no register changes and no `rd_valid`.
- R5: While `wp_n` is 0, write requests and quick commands change neither wipers nor the nonvolatile array and do not raise `busy`. Reads still return data.
- R6: A read request (`req_op`=1) makes `rd_valid` high for one cycle in the next cycle, with the addressed value in `rd_data`. Unimplemented addresses are wiper addresses other than 1 and 3, and nonvolatile addresses 0, 2 and 16 to 31. Reads of them return 0; writes to them are ignored and raise no `busy`.
- R7: Quick command STORE (`req_op`=2, `req_cmd`=2) copies the addressed wiper into its slot and raises `busy` for BUSY_CYCLES cycles.
- R8: Quick command RESTORE (`req_cmd`=1) raises `busy` for RESTORE_CYCLES cycles. The wiper keeps its old value for the whole window and takes its slot value on the edge that ends the window.
- R9: INC (`req_cmd`=3) adds one to the wiper and saturates at all-ones. DEC (`req_cmd`=4) subtracts one and saturates at zero. Both act on the next edge, without `busy`.
- R10: DOUBLE (`req_cmd`=5) turns 0 into 1, turns any value with the top bit set into all-ones, and otherwise shifts left by one. HALVE (`req_cmd`=6) shifts right by one. Both act without `busy`.
- R11: A quick command whose `req_addr` is not 1 or 3 is ignored. So are command codes 0 and 7 to 15. Neither raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; models power-up |
| wp_n | input | 1 | Write enable; 0 blocks all writes and commands |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 0 write, 1 read, 2 quick command, 3 none |
| req_nv | input | 1 | Register space for write/read: 0 wiper, 1 nonvolatile |
| req_addr | input | 5 | Register address, or wiper address for commands |
| req_data | input | 8 | Write data |
| req_cmd | input | 4 | Quick command code |
| busy | output | 1 | High during a nonvolatile or restore window |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Read data |
| wipers | output | 2*W | Wiper values; channel k in bits [k*W +: W] |

## Verification
The checker watches properties on every cycle. A read result only follows an accepted read, and unimplemented reads return zero. Wipers stay frozen while write-protect is low outside a window and for every cycle inside a window. `busy` rises only after a write-type request, and no window outlasts its longest configured length. The bench's scenarios add what a property cannot show: the exact window lengths, the restored and stored values, the saturation points of the step commands, and the 0-to-1 and top-bit-to-full-scale cases of doubling. It also covers rejected commands and protected writes, seen through later reads.

// File: rtl/nvw_pkg.sv
// Shared encodings of the wiper register controller.
// Assumes a byte-wide data path and a five-bit register address.
package nvw_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_CMD   = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;

    typedef enum logic [3:0] {
        QC_NOP     = 4'd0,
        QC_RESTORE = 4'd1,
        QC_STORE   = 4'd2,
        QC_INC     = 4'd3,
        QC_DEC     = 4'd4,
        QC_DOUBLE  = 4'd5,
        QC_HALVE   = 4'd6
    } qcmd_e;

    typedef enum logic [1:0] {
        ADJ_INC    = 2'd0,
        ADJ_DEC    = 2'd1,
        ADJ_DOUBLE = 2'd2,
        ADJ_HALVE  = 2'd3
    } adj_e;
endpackage

// File: rtl/nvw_busy_timer.sv
// Busy window timer. A window opens at reset (power-up restore) or on a start
// pulse. load_mask pulses in the last cycle of a restore window, so that the
// wipers load on the closing edge. Assumes starts only arrive while idle.
module nvw_busy_timer #(
    parameter int NUM_CH         = 2,
    parameter int BUSY_CYCLES    = 2600000,
    parameter int RESTORE_CYCLES = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_nv,
    input  logic              start_rst,
    input  logic [NUM_CH-1:0] rst_mask_in,
    output logic              busy,
    output logic [NUM_CH-1:0] load_mask
);
    localparam int MAXC  = (BUSY_CYCLES > RESTORE_CYCLES) ? BUSY_CYCLES : RESTORE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_CH-1:0] pend_q;

    // Count the window down and remember which channels await a restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_W'(RESTORE_CYCLES);
            pend_q <= '1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                pend_q <= '0;
            end
        end else if (start_rst) begin
            cnt_q  <= CNT_W'(RESTORE_CYCLES);
            pend_q <= rst_mask_in;
        end else if (start_nv) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end
    end

    // Busy flag and restore strobe for the closing edge.
    always_comb begin
        busy      = (cnt_q != '0);
        load_mask = (cnt_q == CNT_W'(1)) ? pend_q : '0;
    end
endmodule

// File: rtl/nvw_nv_array.sv
// Register model of the nonvolatile array: per-wiper slots at odd addresses
// 2k+1 and user bytes in USER_LO..USER_HI. Reset loads the factory image
// (SLOT_INIT in slots, zero elsewhere). Assumes the caller has already
// filtered out writes to unimplemented addresses.
module nvw_nv_array
    import nvw_pkg::*;
#(
    parameter int          W         = 8,
    parameter int          NUM_CH    = 2,
    parameter int          USER_HI   = 15,
    parameter logic [7:0]  SLOT_INIT = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_CH-1:0]   st_mask,
    input  logic [NUM_CH*W-1:0] st_vals,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_val,
    output logic [NUM_CH*W-1:0] slot_vals
);
    localparam int DEPTH = USER_HI + 1;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if ((i % 2 == 1) && (i / 2 < NUM_CH)) begin : g_slot
            localparam int CH = i / 2;
            // Slot cell: store command has priority over a direct write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i] <= SLOT_INIT;
                end else if (st_mask[CH]) begin
                    mem[i] <= DATA_W'(st_vals[CH*W +: W]);
                end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                    mem[i] <= wr_data;
                end
            end
        end else begin : g_user
            // User byte cell: direct writes only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                    mem[i] <= wr_data;
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_out
        // Expose each slot's wiper-width value for restore.
        always_comb slot_vals[k*W +: W] = mem[2*k+1][W-1:0];
    end

    // Combinational read port; out-of-range addresses read zero.
    always_comb begin
        rd_val = (rd_addr < ADDR_W'(DEPTH)) ? mem[rd_addr[IDX_W-1:0]] : '0;
    end
endmodule

// File: rtl/nvw_wiper_bank.sv
// Volatile wiper registers. Per channel, priority is: restore load, then
// direct write, then step adjust. Reset forces midscale. Assumes at most one
// of the three sources targets a channel in a cycle.
module nvw_wiper_bank
    import nvw_pkg::*;
#(
    parameter int W      = 8,
    parameter int NUM_CH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   load_mask,
    input  logic [NUM_CH*W-1:0] load_vals,
    input  logic [NUM_CH-1:0]   wr_mask,
    input  logic [W-1:0]        wr_val,
    input  logic [NUM_CH-1:0]   adj_mask,
    input  adj_e                adj_kind,
    output logic [NUM_CH*W-1:0] wipers
);
    localparam logic [W-1:0] MID  = W'(1) << (W - 1);
    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [W-1:0] cur_q;
        logic [W-1:0] adj_nxt;

        // Next value for the selected step command, with saturation.
        always_comb begin
            unique case (adj_kind)
                ADJ_INC:    adj_nxt = (cur_q == FULL) ? cur_q : cur_q + 1'b1;
                ADJ_DEC:    adj_nxt = (cur_q == '0) ? cur_q : cur_q - 1'b1;
                ADJ_DOUBLE: adj_nxt = (cur_q == '0) ? ONE :
                                      (cur_q[W-1] ? FULL : {cur_q[W-2:0], 1'b0});
                default:    adj_nxt = {1'b0, cur_q[W-1:1]};
            endcase
        end

        // Wiper register update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q <= MID;
            end else if (load_mask[k]) begin
                cur_q <= load_vals[k*W +: W];
            end else if (wr_mask[k]) begin
                cur_q <= wr_val;
            end else if (adj_mask[k]) begin
                cur_q <= adj_nxt;
            end
        end

        // Drive the packed output slice.
        always_comb wipers[k*W +: W] = cur_q;
    end
endmodule

// File: rtl/nvw_ctrl.sv
// Top of the wiper register controller. Decodes single-cycle requests from a
// serial front end into wiper writes, nonvolatile writes, reads and quick
// commands. Honours write protect and the busy window. Assumes the front end
// presents each request for one cycle and NACKs while busy is high.
module nvw_ctrl
    import nvw_pkg::*;
#(
    parameter int         W              = 8,
    parameter int         NUM_CH         = 2,
    parameter int         USER_LO        = 4,
    parameter int         USER_HI        = 15,
    parameter logic [7:0] SLOT_INIT      = 8'h80,
    parameter int         BUSY_CYCLES    = 2600000,
    parameter int         RESTORE_CYCLES = 30000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wp_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic                req_nv,
    input  logic [4:0]          req_addr,
    input  logic [7:0]          req_data,
    input  logic [3:0]          req_cmd,
    output logic                busy,
    output logic                rd_valid,
    output logic [7:0]          rd_data,
    output logic [NUM_CH*W-1:0] wipers
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                accept, mod_ok;
    logic [ADDR_W-2:0]   addr_hi;
    logic                is_wip, is_user, is_nv_impl;
    logic [CH_W-1:0]     ch_idx;
    logic [NUM_CH-1:0]   ch_mask;
    logic                do_wwr, do_nvwr, do_rd, do_cmd;
    logic                start_nv, start_rst;
    logic [NUM_CH-1:0]   st_mask, wr_mask, adj_mask, rst_mask, load_mask;
    adj_e                adj_kind;
    logic [DATA_W-1:0]   nv_rd_val, rd_sel;
    logic [NUM_CH*W-1:0] slot_vals;

    // Address decode and request qualification.
    always_comb begin
        addr_hi    = req_addr[ADDR_W-1:1];
        is_wip     = req_addr[0] && (addr_hi < (ADDR_W-1)'(NUM_CH));
        is_user    = (req_addr >= ADDR_W'(USER_LO)) && (req_addr <= ADDR_W'(USER_HI));
        is_nv_impl = is_wip || is_user;
        ch_idx     = CH_W'(addr_hi);
        ch_mask    = NUM_CH'(1) << ch_idx;
        accept     = req_valid && !busy;
        mod_ok     = accept && wp_n;
        do_wwr     = mod_ok && (req_op == OP_WRITE) && !req_nv && is_wip;
        do_nvwr    = mod_ok && (req_op == OP_WRITE) && req_nv && is_nv_impl;
        do_rd      = accept && (req_op == OP_READ);
        do_cmd     = mod_ok && (req_op == OP_CMD) && is_wip;
    end

    // Quick command decode into store, restore and step actions.
    always_comb begin
        st_mask   = '0;
        rst_mask  = '0;
        adj_mask  = '0;
        adj_kind  = ADJ_INC;
        start_rst = 1'b0;
        if (do_cmd) begin
            unique case (req_cmd)
                QC_RESTORE: begin
                    start_rst = 1'b1;
                    rst_mask  = ch_mask;
                end
                QC_STORE:  st_mask = ch_mask;
                QC_INC: begin
                    adj_mask = ch_mask;
                    adj_kind = ADJ_INC;
                end
                QC_DEC: begin
                    adj_mask = ch_mask;
                    adj_kind = ADJ_DEC;
                end
                QC_DOUBLE: begin
                    adj_mask = ch_mask;
                    adj_kind = ADJ_DOUBLE;
                end
                QC_HALVE: begin
                    adj_mask = ch_mask;
                    adj_kind = ADJ_HALVE;
                end
                default: ;
            endcase
        end
        start_nv = do_nvwr || (st_mask != '0);
        wr_mask  = do_wwr ? ch_mask : '0;
    end

    nvw_busy_timer #(
        .NUM_CH         (NUM_CH),
        .BUSY_CYCLES    (BUSY_CYCLES),
        .RESTORE_CYCLES (RESTORE_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_nv    (start_nv),
        .start_rst   (start_rst),
        .rst_mask_in (rst_mask),
        .busy        (busy),
        .load_mask   (load_mask)
    );

    nvw_nv_array #(
        .W         (W),
        .NUM_CH    (NUM_CH),
        .USER_HI   (USER_HI),
        .SLOT_INIT (SLOT_INIT)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (do_nvwr),
        .wr_addr   (req_addr),
        .wr_data   (req_data),
        .st_mask   (st_mask),
        .st_vals   (wipers),
        .rd_addr   (req_addr),
        .rd_val    (nv_rd_val),
        .slot_vals (slot_vals)
    );

    nvw_wiper_bank #(
        .W      (W),
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mask (load_mask),
        .load_vals (slot_vals),
        .wr_mask   (wr_mask),
        .wr_val    (req_data[W-1:0]),
        .adj_mask  (adj_mask),
        .adj_kind  (adj_kind),
        .wipers    (wipers)
    );

    // Read source select; unimplemented addresses return zero.
    always_comb begin
        if (req_nv) begin
            rd_sel = is_nv_impl ? nv_rd_val : '0;
        end else begin
            rd_sel = is_wip ? DATA_W'(wipers[ch_idx*W +: W]) : '0;
        end
    end

    // Register read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= do_rd;
            if (do_rd) begin
                rd_data <= rd_sel;
            end
        end
    end
endmodule

// File: rtl/nvw_ctrl_chk.sv
// Protocol checker for nvw_ctrl, attached with bind. It observes only ports.
module nvw_ctrl_chk #(
    parameter int W              = 8,
    parameter int NUM_CH         = 2,
    parameter int USER_LO        = 4,
    parameter int USER_HI        = 15,
    parameter int BUSY_CYCLES    = 2600000,
    parameter int RESTORE_CYCLES = 30000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wp_n,
    input logic                req_valid,
    input logic [1:0]          req_op,
    input logic                req_nv,
    input logic [4:0]          req_addr,
    input logic                busy,
    input logic                rd_valid,
    input logic [7:0]          rd_data,
    input logic [NUM_CH*W-1:0] wipers
);
    localparam int LIMIT = (BUSY_CYCLES > RESTORE_CYCLES) ? BUSY_CYCLES : RESTORE_CYCLES;

    logic wip_ok, unimpl;
    int   busy_run;

    // Independent view of which addresses are backed by storage.
    always_comb begin
        wip_ok = req_addr[0] && (int'(req_addr) / 2 < NUM_CH);
        unimpl = req_nv ? !(wip_ok || (int'(req_addr) >= USER_LO && int'(req_addr) <= USER_HI))
                        : !wip_ok;
    end

    // Length of the current busy run, in cycles already completed.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    AST_RD_FOLLOWS_ACCEPTED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !busy && req_op == 2'd1));        // R4
    AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(unimpl)) |-> (rd_data == 8'd0));               // R6
    AST_WP_FREEZES_WIPERS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wp_n && !busy) |-> $stable(wipers));                       // R5
    AST_BUSY_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && wp_n && req_op != 2'd1));      // R3
    AST_WIPERS_FROZEN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(wipers));                       // R8
    AST_NO_ENDLESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < LIMIT));                                     // R3
endmodule

bind nvw_ctrl nvw_ctrl_chk #(
    .W              (W),
    .NUM_CH         (NUM_CH),
    .USER_LO        (USER_LO),
    .USER_HI        (USER_HI),
    .BUSY_CYCLES    (BUSY_CYCLES),
    .RESTORE_CYCLES (RESTORE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_nv    (req_nv),
    .req_addr  (req_addr),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wipers    (wipers)
);

// File: tb/nvw_ctrl_tb.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks with literal expectations.
module nvw_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int NCH        = 2;
    localparam int BUSY_T     = 12;
    localparam int RESTORE_T  = 5;
    localparam int INIT_V     = 'h33;
    localparam int FULLV      = (1 << W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wp_n = 1'b1;
    logic           req_valid = 1'b0;
    logic [1:0]     req_op = 2'd3;
    logic           req_nv = 1'b0;
    logic [4:0]     req_addr = '0;
    logic [7:0]     req_data = '0;
    logic [3:0]     req_cmd = '0;
    logic           busy, rd_valid;
    logic [7:0]     rd_data;
    logic [NCH*W-1:0] wipers;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int m_wip[NCH];
    int m_nv[16];
    int m_cnt;
    bit m_pend[NCH];
    bit m_rdv;
    int m_rdd;

    nvw_ctrl #(
        .W(W), .NUM_CH(NCH), .USER_LO(4), .USER_HI(15), .SLOT_INIT(8'(INIT_V)),
        .BUSY_CYCLES(BUSY_T), .RESTORE_CYCLES(RESTORE_T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid),
        .req_op(req_op), .req_nv(req_nv), .req_addr(req_addr),
        .req_data(req_data), .req_cmd(req_cmd), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .wipers(wipers)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int wip(int k);
        return int'(wipers[k*W +: W]);
    endfunction

    function automatic bit wip_addr(int a);
        return (a % 2 == 1) && (a / 2 < NCH);
    endfunction

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_wip[k]) begin m_wip[k] = 1 << (W - 1); m_pend[k] = 1'b1; end
            foreach (m_nv[i]) m_nv[i] = wip_addr(i) ? INIT_V : 0;
            m_cnt = RESTORE_T;
            m_rdv = 1'b0;
        end else begin
            m_rdv = 1'b0;
            if (m_cnt > 0) begin
                if (m_cnt == 1) begin
                    foreach (m_wip[k]) if (m_pend[k]) m_wip[k] = m_nv[2*k+1] % (1 << W);
                    foreach (m_pend[k]) m_pend[k] = 1'b0;
                end
                m_cnt = m_cnt - 1;
            end else if (req_valid) begin
                automatic int a  = int'(req_addr);
                automatic int ch = a / 2;
                if (req_op == 2'd1) begin
                    m_rdv = 1'b1;
                    if (req_nv) m_rdd = (wip_addr(a) || (a >= 4 && a <= 15)) ? m_nv[a] : 0;
                    else        m_rdd = wip_addr(a) ? m_wip[ch] : 0;
                end else if (wp_n && req_op == 2'd0) begin
                    if (!req_nv && wip_addr(a)) m_wip[ch] = int'(req_data) % (1 << W);
                    else if (req_nv && (wip_addr(a) || (a >= 4 && a <= 15))) begin
                        m_nv[a] = int'(req_data);
                        m_cnt = BUSY_T;
                    end
                end else if (wp_n && req_op == 2'd2 && wip_addr(a)) begin
                    automatic int v = m_wip[ch];
                    case (int'(req_cmd))
                        1: begin m_pend[ch] = 1'b1; m_cnt = RESTORE_T; end
                        2: begin m_nv[a] = v; m_cnt = BUSY_T; end
                        3: m_wip[ch] = (v == FULLV) ? v : v + 1;
                        4: m_wip[ch] = (v == 0) ? 0 : v - 1;
                        5: m_wip[ch] = (v == 0) ? 1 : (v >= (1 << (W - 1))) ? FULLV : v * 2;
                        6: m_wip[ch] = v / 2;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Cycle compare against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk({cur_req, " busy"}, int'(busy), int'(m_cnt > 0));
            chk({cur_req, " rd_valid"}, int'(rd_valid), int'(m_rdv));
            if (m_rdv) chk({cur_req, " rd_data"}, int'(rd_data), m_rdd);
            for (int k = 0; k < NCH; k++) chk({cur_req, " wiper"}, wip(k), m_wip[k]);
        end
    end

    // Present one request for one cycle; returns at the next falling edge.
    task automatic send(int op, bit nv, int addr, int data, int cmd);
        req_valid = 1'b1; req_op = 2'(op); req_nv = nv;
        req_addr = 5'(addr); req_data = 8'(data); req_cmd = 4'(cmd);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd3;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd_chk(string tag, bit nv, int addr, int exp);
        send(1, nv, addr, 0, 0);
        chk({tag, " read valid"}, int'(rd_valid), 1);
        chk({tag, " read data"}, int'(rd_data), exp);
    endtask

    task automatic win_len(string tag, int exp);
        automatic int n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk({tag, " window"}, n, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 busy in reset", int'(busy), 1);
        chk("R1 mid ch0", wip(0), 'h80);
        chk("R1 mid ch1", wip(1), 'h80);
        rst_n = 1'b1;
        repeat (RESTORE_T - 1) @(negedge clk);
        chk("R1 still mid", wip(0), 'h80);
        @(negedge clk);
        chk("R1 restored ch0", wip(0), INIT_V);
        chk("R1 restored ch1", wip(1), INIT_V);

        cur_req = "R2";
        send(0, 0, 1, 'h10, 0);
        chk("R2 ch0 written", wip(0), 'h10);
        chk("R2 no busy", int'(busy), 0);
        send(0, 0, 3, 'hF0, 0);
        chk("R2 ch1 written", wip(1), 'hF0);

        cur_req = "R6";
        rd_chk("R6 wiper", 0, 3, 'hF0);
        send(0, 0, 2, 'h55, 0);
        rd_chk("R6 unimpl wiper", 0, 2, 0);
        send(0, 1, 0, 'h55, 0);
        chk("R6 unimpl nv no busy", int'(busy), 0);
        rd_chk("R6 unimpl nv", 1, 20, 0);
        rd_chk("R6 slot", 1, 3, INIT_V);

        cur_req = "R3";
        send(0, 1, 7, 'hA5, 0);
        win_len("R3 nv write", BUSY_T);
        rd_chk("R3 user byte", 1, 7, 'hA5);
        send(0, 1, 15, 'h3C, 0);
        cur_req = "R4";
        send(0, 0, 1, 'h99, 0);
        chk("R4 write dropped", wip(0), 'h10);
        send(1, 0, 1, 0, 0);
        chk("R4 read dropped", int'(rd_valid), 0);
        send(2, 0, 1, 0, 3);
        chk("R4 cmd dropped", wip(0), 'h10);
        wait_idle();
        rd_chk("R4 last user byte", 1, 15, 'h3C);

        cur_req = "R7";
        send(2, 0, 1, 0, 2);
        win_len("R7 store", BUSY_T);
        rd_chk("R7 slot", 1, 1, 'h10);

        cur_req = "R8";
        send(0, 0, 1, 'h77, 0);
        send(2, 0, 1, 0, 1);
        repeat (RESTORE_T - 1) @(negedge clk);
        chk("R8 old value held", wip(0), 'h77);
        @(negedge clk);
        chk("R8 restored", wip(0), 'h10);
        chk("R8 window closed", int'(busy), 0);

        cur_req = "R9";
        send(0, 0, 1, 'hFF, 0);
        send(2, 0, 1, 0, 3);
        chk("R9 inc saturates", wip(0), 'hFF);
        send(2, 0, 3, 0, 3);
        chk("R9 inc", wip(1), 'hF1);
        send(0, 0, 3, 0, 0);
        send(2, 0, 3, 0, 4);
        chk("R9 dec saturates", wip(1), 0);
        send(2, 0, 1, 0, 4);
        chk("R9 dec", wip(0), 'hFE);

        cur_req = "R10";
        send(2, 0, 3, 0, 5);
        chk("R10 double zero", wip(1), 1);
        send(0, 0, 3, 'h41, 0);
        send(2, 0, 3, 0, 5);
        chk("R10 double", wip(1), 'h82);
        send(2, 0, 3, 0, 5);
        chk("R10 double top bit", wip(1), 'hFF);
        send(2, 0, 3, 0, 6);
        chk("R10 halve", wip(1), 'h7F);
        send(0, 0, 3, 1, 0);
        send(2, 0, 3, 0, 6);
        chk("R10 halve one", wip(1), 0);

        cur_req = "R11";
        send(2, 0, 2, 0, 3);
        send(2, 0, 5, 0, 2);
        chk("R11 bad addr no busy", int'(busy), 0);
        send(2, 0, 1, 0, 9);
        chk("R11 reserved code", wip(0), 'hFE);
        chk("R11 reserved no busy", int'(busy), 0);

        cur_req = "R5";
        wp_n = 1'b0;
        send(0, 0, 1, 'h22, 0);
        chk("R5 wiper write blocked", wip(0), 'hFE);
        send(0, 1, 9, 'h22, 0);
        chk("R5 nv write no busy", int'(busy), 0);
        send(2, 0, 1, 0, 2);
        chk("R5 store no busy", int'(busy), 0);
        send(2, 0, 1, 0, 4);
        rd_chk("R5 read works", 0, 1, 'hFE);
        rd_chk("R5 nv unchanged", 1, 9, 0);
        rd_chk("R5 slot unchanged", 1, 1, 'h10);
        wp_n = 1'b1;

        cur_req = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 second reset mid", wip(0), 'h80);
        rst_n = 1'b1;
        wait_idle();
        chk("R1 second restore", wip(0), INIT_V);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule